// File: doc/BRIEF.md
# D-PHY Data Lane HS Burst Sequencer

This block sequences one transmit data lane of a D-PHY link at byte granularity. From the stop state it waits for a burst request and for the clock lane to report that it is ready. It then walks the lane through the low-power request states (LP-01 and then LP-00), holds HS-0 zero and, if enabled, sends a preamble of 0xAA bytes. It follows with the sync byte 0xB8 and streams payload bytes taken from a valid/ready/last byte interface. After the last byte it drives a trail state that is the inverse of the final transmitted bit (bytes leave LSB first, so this is bit 7). It then holds LP-11 for an exit interval before it reports that the lane is idle again.

The same lane can be parked in ultra-low-power state. An escape mark (LP-10) leads into LP-00, which is held until an exit pulse arrives. The exit drives a Mark-1 (LP-10) wake period and then an LP-11 gap before the lane becomes usable again. After reset the lane holds LP-11 for a programmable initialisation time and ignores every request during it.

Every phase length comes from a static configuration input with a fixed offset. The output is the byte-level line state: a two-bit LP level, an HS enable and the HS byte. A serializer downstream turns it into the wire signal.

Top module: `dphy_lane_seq`

## Requirements
- R1: After reset release the lane shows LP-11 (`lp_state`=2'b11, bit 1 is the P wire and bit 0 the N wire), with `lane_idle` and `s_ready` low, for max(cfg_init,1)+1 cycles, ignoring `tx_req`; `lane_idle` then rises.
- R2: In the idle stop state, `tx_req` high together with `clk_ready` high starts LP-01 (`lp_state`=2'b01) for LPX_CYC cycles; with `clk_ready` low the lane stays in idle LP-11.
- R3: LP-00 prepare (`lp_state`=2'b00, `hs_en` low) lasts cfg_prepare+2 cycles.
- R4: HS-0 zero (`hs_en` high, `hs_byte`=8'h00) lasts cfg_zero+4 cycles.
- R5: With `cfg_pre_en` high, (cfg_pre_len+1)*4 bytes of 8'hAA follow HS zero; with it low, no preamble byte is sent.
- R6: Exactly one sync byte 8'hB8 is sent, and `s_ready` is high during it.
- R7: Each byte accepted (`s_valid` and `s_ready` high at a clock edge) is sent on `hs_byte` in the following cycle, in order. `s_ready` is low in the cycle that sends a byte flagged with `s_last`, and low outside sync and payload.
- R8: After the final byte the lane sends max(cfg_trail,1) bytes whose bits all equal the inverse of bit 7 of the last byte sent.
- R9: If `s_valid` is low while `s_ready` is high, the burst ends in trail at once, based on the last byte sent (the sync byte when no payload was sent, giving 8'h00).
- R10: After trail the lane shows LP-11 with `lane_idle` low for max(cfg_hs_exit,1) cycles, then `lane_idle` high.
- R11: In idle stop with `tx_req` low, `ulps_req` gives LP-10 for LPX_CYC cycles, then LP-00 held indefinitely; `tx_req` has no effect while held.
- R12: An `ulps_exit` pulse during the LP-00 hold gives Mark-1 (LP-10) for max(cfg_wake,1) cycles, then LP-11 with `lane_idle` low for max(cfg_lp_exit,1) cycles, then `lane_idle` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_prepare | input | 6 | LP-00 prepare setting |
| cfg_zero | input | 8 | HS-0 zero setting |
| cfg_trail | input | 8 | Trail length in cycles |
| cfg_hs_exit | input | 8 | LP-11 hold after a burst |
| cfg_lp_exit | input | 8 | LP-11 gap after wake |
| cfg_wake | input | 8 | Mark-1 wake length |
| cfg_init | input | 8 | Initialisation hold after reset |
| cfg_pre_en | input | 1 | Preamble enable |
| cfg_pre_len | input | 4 | Preamble length in 32-UI steps minus one |
| tx_req | input | 1 | Burst request |
| clk_ready | input | 1 | Clock lane is running HS clock |
| ulps_req | input | 1 | Ultra-low-power entry request |
| ulps_exit | input | 1 | Ultra-low-power exit pulse |
| s_valid | input | 1 | Payload byte valid |
| s_data | input | 8 | Payload byte |
| s_last | input | 1 | Payload byte is the final one |
| s_ready | output | 1 | Payload byte accepted at next edge |
| lp_state | output | 2 | LP level: bit 1 P wire, bit 0 N wire |
| hs_en | output | 1 | HS byte on `hs_byte` is valid |
| hs_byte | output | 8 | HS byte, LSB sent first |
| lane_idle | output | 1 | Lane settled in stop and able to start |

## Verification
The hardest case to reach from the ports is a burst cut short by a gap in the payload. This is hardest when the gap falls on the sync cycle itself, where the trail level must come from the sync byte rather than from any payload byte. The vector table gives each burst a cut point in addition to its length. The bench withholds `s_valid` from that byte index onward, which places the cut on the sync cycle, in the middle of the payload, or nowhere. Exit lengths are pinned by the exact cycle in which `lane_idle` rises. A parked lane is held for several cycles under an active `tx_req` to show that the request does not leak through.

// File: rtl/dls_pkg.sv
package dls_pkg;

  localparam int BYTE_W = 8;

  localparam logic [1:0] LP11 = 2'b11;
  localparam logic [1:0] LP01 = 2'b01;
  localparam logic [1:0] LP10 = 2'b10;
  localparam logic [1:0] LP00 = 2'b00;

  localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'hB8;
  localparam logic [BYTE_W-1:0] PRE_BYTE  = 8'hAA;
  localparam int PRE_BYTES_PER_STEP_LOG2  = 2;

  typedef enum logic [3:0] {
    ST_RST,
    ST_INIT,
    ST_STOP,
    ST_REQ,
    ST_PREP,
    ST_ZERO,
    ST_PRE,
    ST_SYNC,
    ST_DATA,
    ST_TRAIL,
    ST_EXIT,
    ST_ESC,
    ST_ULPS,
    ST_WAKE,
    ST_GAP
  } lane_st_t;

endpackage

// File: rtl/dls_timer.sv
module dls_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

  // R4: an expired phase counter stays expired until the next load
  p_timer_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> done);

endmodule

// File: rtl/dls_ctrl.sv
module dls_ctrl
  import dls_pkg::*;
#(
  parameter int TW      = 8,
  parameter int PW      = 6,
  parameter int PLW     = 4,
  parameter int LPX_CYC = 2,
  parameter int CNT_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PW-1:0]     cfg_prepare,
  input  logic [TW-1:0]     cfg_zero,
  input  logic [TW-1:0]     cfg_trail,
  input  logic [TW-1:0]     cfg_hs_exit,
  input  logic [TW-1:0]     cfg_lp_exit,
  input  logic [TW-1:0]     cfg_wake,
  input  logic [TW-1:0]     cfg_init,
  input  logic              cfg_pre_en,
  input  logic [PLW-1:0]    cfg_pre_len,
  input  logic              tx_req,
  input  logic              clk_ready,
  input  logic              ulps_req,
  input  logic              ulps_exit,
  input  logic              s_valid,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_last,
  input  logic              tmr_done,
  output logic              s_ready,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output lane_st_t          state_q,
  output logic [BYTE_W-1:0] byte_q,
  output logic [BYTE_W-1:0] fill_q
);

  localparam logic [CNT_W-1:0] LPX_LEN = (LPX_CYC < 1) ? CNT_W'(1) : CNT_W'(LPX_CYC);

  lane_st_t          state_d;
  logic              last_q;
  logic              capture;
  logic              fill_en;
  logic              end_bit;
  logic [CNT_W-1:0]  len_d;

  function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  // payload handshake
  always_comb begin
    s_ready = (state_q == ST_SYNC) || ((state_q == ST_DATA) && !last_q);
    capture = s_ready && s_valid;
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RST:   state_d = ST_INIT;
      ST_INIT:  if (tmr_done) state_d = ST_STOP;
      ST_STOP: begin
        if (tx_req && clk_ready)  state_d = ST_REQ;
        else if (ulps_req && !tx_req) state_d = ST_ESC;
      end
      ST_REQ:   if (tmr_done) state_d = ST_PREP;
      ST_PREP:  if (tmr_done) state_d = ST_ZERO;
      ST_ZERO:  if (tmr_done) state_d = cfg_pre_en ? ST_PRE : ST_SYNC;
      ST_PRE:   if (tmr_done) state_d = ST_SYNC;
      ST_SYNC:  state_d = s_valid ? ST_DATA : ST_TRAIL;
      ST_DATA:  if (last_q || !s_valid) state_d = ST_TRAIL;
      ST_TRAIL: if (tmr_done) state_d = ST_EXIT;
      ST_EXIT:  if (tmr_done) state_d = ST_STOP;
      ST_ESC:   if (tmr_done) state_d = ST_ULPS;
      ST_ULPS:  if (ulps_exit) state_d = ST_WAKE;
      ST_WAKE:  if (tmr_done) state_d = ST_GAP;
      ST_GAP:   if (tmr_done) state_d = ST_STOP;
      default:  state_d = ST_RST;
    endcase
  end

  // phase length for the state being entered
  always_comb begin
    unique case (state_d)
      ST_INIT:        len_d = at_least_one(CNT_W'(cfg_init));
      ST_REQ, ST_ESC: len_d = LPX_LEN;
      ST_PREP:        len_d = CNT_W'(cfg_prepare) + CNT_W'(2);
      ST_ZERO:        len_d = CNT_W'(cfg_zero) + CNT_W'(4);
      ST_PRE:         len_d = (CNT_W'(cfg_pre_len) + CNT_W'(1)) << PRE_BYTES_PER_STEP_LOG2;
      ST_TRAIL:       len_d = at_least_one(CNT_W'(cfg_trail));
      ST_EXIT:        len_d = at_least_one(CNT_W'(cfg_hs_exit));
      ST_WAKE:        len_d = at_least_one(CNT_W'(cfg_wake));
      ST_GAP:         len_d = at_least_one(CNT_W'(cfg_lp_exit));
      default:        len_d = CNT_W'(1);
    endcase
    tmr_load = (state_d != state_q);
    tmr_val  = len_d - CNT_W'(1);
  end

  // trail level comes from the last bit on the wire (MSB, sent last)
  always_comb begin
    end_bit = (state_q == ST_SYNC) ? SYNC_BYTE[BYTE_W-1] : byte_q[BYTE_W-1];
    fill_en = (state_d == ST_TRAIL) && (state_q != ST_TRAIL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RST;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      last_q <= 1'b0;
    end else if (capture) begin
      byte_q <= s_data;
      last_q <= s_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
    end else if (fill_en) begin
      fill_q <= {BYTE_W{~end_bit}};
    end
  end

  // R3: a timed phase is never left before its counter expires
  p_phase_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q inside {ST_INIT, ST_REQ, ST_PREP, ST_ZERO, ST_PRE, ST_TRAIL,
                      ST_EXIT, ST_ESC, ST_WAKE, ST_GAP}) && !tmr_done)
    |=> (state_q == $past(state_q)));

  // R8: trail entered from payload inverts the final payload bit
  p_fill_inverse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_TRAIL) && ($past(state_q) == ST_DATA))
    |-> (fill_q == {BYTE_W{~$past(byte_q[BYTE_W-1])}}));

  // R11: the parked state is held until the exit pulse
  p_ulps_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_ULPS) && !ulps_exit) |=> (state_q == ST_ULPS));

endmodule

// File: rtl/dls_linemux.sv
module dls_linemux
  import dls_pkg::*;
(
  input  lane_st_t          state,
  input  logic [BYTE_W-1:0] byte_q,
  input  logic [BYTE_W-1:0] fill_q,
  output logic [1:0]        lp_state,
  output logic              hs_en,
  output logic [BYTE_W-1:0] hs_byte,
  output logic              lane_idle
);

  always_comb begin
    lp_state  = LP00;
    hs_en     = 1'b0;
    hs_byte   = '0;
    lane_idle = (state == ST_STOP);
    unique case (state)
      ST_RST, ST_INIT, ST_STOP, ST_EXIT, ST_GAP: lp_state = LP11;
      ST_REQ:           lp_state = LP01;
      ST_ESC, ST_WAKE:  lp_state = LP10;
      ST_PREP, ST_ULPS: lp_state = LP00;
      ST_ZERO:  begin hs_en = 1'b1; hs_byte = '0;        end
      ST_PRE:   begin hs_en = 1'b1; hs_byte = PRE_BYTE;  end
      ST_SYNC:  begin hs_en = 1'b1; hs_byte = SYNC_BYTE; end
      ST_DATA:  begin hs_en = 1'b1; hs_byte = byte_q;    end
      ST_TRAIL: begin hs_en = 1'b1; hs_byte = fill_q;    end
      default:  lp_state = LP11;
    endcase
  end

endmodule

// File: rtl/dphy_lane_seq.sv
module dphy_lane_seq
  import dls_pkg::*;
#(
  parameter int TW      = 8,
  parameter int PW      = 6,
  parameter int PLW     = 4,
  parameter int LPX_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PW-1:0]     cfg_prepare,
  input  logic [TW-1:0]     cfg_zero,
  input  logic [TW-1:0]     cfg_trail,
  input  logic [TW-1:0]     cfg_hs_exit,
  input  logic [TW-1:0]     cfg_lp_exit,
  input  logic [TW-1:0]     cfg_wake,
  input  logic [TW-1:0]     cfg_init,
  input  logic              cfg_pre_en,
  input  logic [PLW-1:0]    cfg_pre_len,
  input  logic              tx_req,
  input  logic              clk_ready,
  input  logic              ulps_req,
  input  logic              ulps_exit,
  input  logic              s_valid,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_last,
  output logic              s_ready,
  output logic [1:0]        lp_state,
  output logic              hs_en,
  output logic [BYTE_W-1:0] hs_byte,
  output logic              lane_idle
);

  localparam int TW_CNT  = ((TW > PW) ? TW : PW) + 1;
  localparam int PL_CNT  = PLW + PRE_BYTES_PER_STEP_LOG2 + 1;
  localparam int CNT_W   = (TW_CNT > PL_CNT) ? TW_CNT : PL_CNT;

  lane_st_t          state_q;
  logic [BYTE_W-1:0] byte_q;
  logic [BYTE_W-1:0] fill_q;
  logic              tmr_load;
  logic              tmr_done;
  logic [CNT_W-1:0]  tmr_val;

  dls_ctrl #(
    .TW(TW), .PW(PW), .PLW(PLW), .LPX_CYC(LPX_CYC), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_prepare(cfg_prepare), .cfg_zero(cfg_zero), .cfg_trail(cfg_trail),
    .cfg_hs_exit(cfg_hs_exit), .cfg_lp_exit(cfg_lp_exit), .cfg_wake(cfg_wake),
    .cfg_init(cfg_init), .cfg_pre_en(cfg_pre_en), .cfg_pre_len(cfg_pre_len),
    .tx_req(tx_req), .clk_ready(clk_ready), .ulps_req(ulps_req), .ulps_exit(ulps_exit),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .tmr_done(tmr_done),
    .s_ready(s_ready), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .state_q(state_q), .byte_q(byte_q), .fill_q(fill_q)
  );

  dls_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  dls_linemux mux_i (
    .state(state_q), .byte_q(byte_q), .fill_q(fill_q),
    .lp_state(lp_state), .hs_en(hs_en), .hs_byte(hs_byte), .lane_idle(lane_idle)
  );

  // R6: payload is only ever accepted while the lane is in HS mode
  p_ready_in_hs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> hs_en);

  // R2: leaving idle into LP-01 needs both request and clock lane readiness
  p_req_needs_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((lp_state == LP01) && $past(lane_idle)) |-> $past(tx_req && clk_ready));

  // R12: a step from parked LP-00 up to Mark-1 only follows an exit pulse
  p_wake_entry_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((lp_state == LP10) && ($past(lp_state) == LP00) && !$past(hs_en))
    |-> $past(ulps_exit));

endmodule

// File: tb/dphy_lane_seq_tb_top.sv
module dphy_lane_seq_tb_top;

  localparam int LPX = 2;

  typedef struct packed {
    logic [5:0] prep;
    logic [7:0] zero;
    logic [7:0] trail;
    logic [7:0] hexit;
    logic       pre_en;
    logic [3:0] pre_len;
    logic [7:0] nb;
    logic [7:0] cut;
    logic [7:0] seed;
  } vec_t;

  // cut >= nb means no gap in the payload
  localparam vec_t VECS [6] = '{
    '{6'd3, 8'd4, 8'd8, 8'd12, 1'b0, 4'd0, 8'd4, 8'd255, 8'h10},
    '{6'd0, 8'd0, 8'd0, 8'd0,  1'b1, 4'd0, 8'd3, 8'd255, 8'h81},
    '{6'd5, 8'd2, 8'd3, 8'd2,  1'b1, 4'd3, 8'd6, 8'd255, 8'h7F},
    '{6'd1, 8'd1, 8'd2, 8'd1,  1'b0, 4'd0, 8'd5, 8'd2,   8'h55},
    '{6'd2, 8'd0, 8'd4, 8'd3,  1'b0, 4'd0, 8'd3, 8'd0,   8'h00},
    '{6'd0, 8'd3, 8'd1, 8'd1,  1'b1, 4'd1, 8'd1, 8'd255, 8'hFE}
  };

  logic       clk;
  logic       rst_n;
  logic [5:0] cfg_prepare;
  logic [7:0] cfg_zero, cfg_trail, cfg_hs_exit, cfg_lp_exit, cfg_wake, cfg_init;
  logic       cfg_pre_en;
  logic [3:0] cfg_pre_len;
  logic       tx_req, clk_ready, ulps_req, ulps_exit;
  logic       s_valid, s_last, s_ready;
  logic [7:0] s_data;
  logic [1:0] lp_state;
  logic       hs_en, lane_idle;
  logic [7:0] hs_byte;

  int n_vec;
  int n_bad;
  int cyc;

  logic [12:0] exp_v [0:511];
  string       exp_r [0:511];
  int          exp_n;

  dphy_lane_seq #(.LPX_CYC(LPX)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_prepare(cfg_prepare), .cfg_zero(cfg_zero), .cfg_trail(cfg_trail),
    .cfg_hs_exit(cfg_hs_exit), .cfg_lp_exit(cfg_lp_exit), .cfg_wake(cfg_wake),
    .cfg_init(cfg_init), .cfg_pre_en(cfg_pre_en), .cfg_pre_len(cfg_pre_len),
    .tx_req(tx_req), .clk_ready(clk_ready), .ulps_req(ulps_req), .ulps_exit(ulps_exit),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .lp_state(lp_state), .hs_en(hs_en), .hs_byte(hs_byte), .lane_idle(lane_idle)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  // {ready, idle, hs_en, lp[1:0], byte}
  function automatic logic [12:0] mk(input logic rdy, input logic idl, input logic hs,
                                     input logic [1:0] lp, input logic [7:0] b);
    return {rdy, idl, hs, lp, b};
  endfunction

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed + 8'(i * 37);
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic cmp(input logic [12:0] e, input string tag);
    logic [12:0] a;
    a = {s_ready, lane_idle, hs_en, lp_state, hs_byte};
    n_vec = n_vec + 1;
    if (a !== e) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual rdy=%b idle=%b hs=%b lp=%b byte=%h expected rdy=%b idle=%b hs=%b lp=%b byte=%h",
               tag, a[12], a[11], a[10], a[9:8], a[7:0], e[12], e[11], e[10], e[9:8], e[7:0]);
    end
  endtask

  task automatic push(input logic [12:0] v, input string tag);
    exp_v[exp_n] = v;
    exp_r[exp_n] = tag;
    exp_n = exp_n + 1;
  endtask

  task automatic run_vec(input vec_t v);
    int         nsend;
    int         idx;
    logic       acc_prev;
    logic [7:0] lastb;
    int         trl, hex;
    nsend = (v.cut < v.nb) ? int'(v.cut) : int'(v.nb);
    cfg_prepare = v.prep; cfg_zero = v.zero; cfg_trail = v.trail;
    cfg_hs_exit = v.hexit; cfg_pre_en = v.pre_en; cfg_pre_len = v.pre_len;
    exp_n = 0;
    for (int i = 0; i < LPX; i++) push(mk(0, 0, 0, 2'b01, 8'h00), "R2");
    for (int i = 0; i < int'(v.prep) + 2; i++) push(mk(0, 0, 0, 2'b00, 8'h00), "R3");
    for (int i = 0; i < int'(v.zero) + 4; i++) push(mk(0, 0, 1, 2'b00, 8'h00), "R4");
    if (v.pre_en)
      for (int i = 0; i < (int'(v.pre_len) + 1) * 4; i++) push(mk(0, 0, 1, 2'b00, 8'hAA), "R5");
    push(mk(1, 0, 1, 2'b00, 8'hB8), "R6");
    for (int i = 0; i < nsend; i++)
      push(mk((nsend == int'(v.nb) && i == nsend - 1) ? 1'b0 : 1'b1, 0, 1, 2'b00, pat(v.seed, i)), "R7");
    lastb = (nsend == 0) ? 8'hB8 : pat(v.seed, nsend - 1);
    trl = (v.trail == 0) ? 1 : int'(v.trail);
    for (int i = 0; i < trl; i++)
      push(mk(0, 0, 1, 2'b00, {8{~lastb[7]}}), (nsend < int'(v.nb)) ? "R9" : "R8");
    hex = (v.hexit == 0) ? 1 : int'(v.hexit);
    for (int i = 0; i < hex; i++) push(mk(0, 0, 0, 2'b11, 8'h00), "R10");
    push(mk(0, 1, 0, 2'b11, 8'h00), "R10");

    idx = 0;
    s_valid = (nsend > 0);
    s_data  = pat(v.seed, 0);
    s_last  = (nsend == int'(v.nb)) && (v.nb == 1);
    acc_prev = 1'b0;
    tx_req  = 1'b1;
    for (int i = 0; i < exp_n; i++) begin
      step();
      if (acc_prev) idx = idx + 1;
      s_valid  = (idx < nsend);
      s_data   = pat(v.seed, idx);
      s_last   = (nsend == int'(v.nb)) && (idx == int'(v.nb) - 1);
      acc_prev = s_ready && s_valid;
      if (i == 0) tx_req = 1'b0;
      cmp(exp_v[i], exp_r[i]);
    end
    s_valid = 1'b0;
    s_last  = 1'b0;
  endtask

  task automatic run_ulps(input logic [7:0] wake, input logic [7:0] gap);
    int wk, gp;
    cfg_wake = wake; cfg_lp_exit = gap;
    wk = (wake == 0) ? 1 : int'(wake);
    gp = (gap == 0) ? 1 : int'(gap);
    ulps_req = 1'b1;
    for (int i = 0; i < LPX; i++) begin
      step();
      ulps_req = 1'b0;
      cmp(mk(0, 0, 0, 2'b10, 8'h00), "R11 escape mark");
    end
    tx_req = 1'b1;
    clk_ready = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step();
      cmp(mk(0, 0, 0, 2'b00, 8'h00), "R11 parked, tx_req ignored");
    end
    tx_req = 1'b0;
    ulps_exit = 1'b1;
    step();
    ulps_exit = 1'b0;
    cmp(mk(0, 0, 0, 2'b10, 8'h00), "R12 wake");
    for (int i = 1; i < wk; i++) begin
      step();
      cmp(mk(0, 0, 0, 2'b10, 8'h00), "R12 wake");
    end
    for (int i = 0; i < gp; i++) begin
      step();
      cmp(mk(0, 0, 0, 2'b11, 8'h00), "R12 gap");
    end
    step();
    cmp(mk(0, 1, 0, 2'b11, 8'h00), "R12 idle after gap");
  endtask

  initial begin
    n_vec = 0; n_bad = 0; cyc = 0;
    rst_n = 1'b0;
    cfg_prepare = 6'd3; cfg_zero = 8'd4; cfg_trail = 8'd8; cfg_hs_exit = 8'd12;
    cfg_lp_exit = 8'd12; cfg_wake = 8'd111; cfg_init = 8'd12;
    cfg_pre_en = 1'b0; cfg_pre_len = 4'd0;
    tx_req = 1'b1; clk_ready = 1'b1; ulps_req = 1'b0; ulps_exit = 1'b0;
    s_valid = 1'b0; s_data = 8'h00; s_last = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: init hold with a pending request that must be ignored
    for (int i = 1; i <= 12; i++) begin
      step();
      cmp(mk(0, 0, 0, 2'b11, 8'h00), "R1 init hold");
      if (i == 12) tx_req = 1'b0;
    end
    step();
    cmp(mk(0, 1, 0, 2'b11, 8'h00), "R1 idle after init");

    // R2: request without clock lane readiness stays idle
    clk_ready = 1'b0;
    tx_req = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step();
      cmp(mk(0, 1, 0, 2'b11, 8'h00), "R2 waits for clk_ready");
    end
    tx_req = 1'b0;
    clk_ready = 1'b1;
    step();
    cmp(mk(0, 1, 0, 2'b11, 8'h00), "R2 no request");

    // table of bursts
    for (int k = 0; k < 6; k++) run_vec(VECS[k]);

    // ultra-low-power entry and exit
    run_ulps(8'd5, 8'd3);
    run_ulps(8'd0, 8'd0);

    // burst straight after a wake
    run_vec(VECS[1]);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule